// File: doc/BRIEF.md
# SPI Slave Command Frame Decoder

This block sits on the device side of a serial peripheral link, downstream of the bit shifter that turns the serial line into bytes. While chip select is low, the first byte it receives is taken as an opcode. The opcode fixes how many parameter bytes follow. The block gathers those bytes and, when checking is enabled, compares a trailing CRC7 byte against a checksum computed over the frame. A good frame produces a one-cycle command strobe carrying the opcode, the address, the transfer size, the write data and the internal-access flag, all in decoded form. The register file and the DMA engine act on that strobe.

Every frame gets a short answer back on the transmit side: the opcode echoed, then a status byte. The three control opcodes send one filler byte before the echo. The answer is offered one byte at a time through a valid/ready pair, so the shifter can take each byte when it has a slot for it. Once a frame has finished, the block ignores all further traffic until chip select goes high. Chip select going high at any point drops a partial frame and any answer still pending.

Top module: `spi_cmd_decoder`

## Requirements
- R1: Known opcodes and their parameter byte counts are 0xCA single read 3, 0xC9 single write 7, 0xC2 and 0xC1 DMA read and write 5, 0xC8 and 0xC7 extended DMA read and write 6, 0xC4 internal read 3, 0xC3 internal write 6, and 0xC5 terminate, 0xC6 repeat and 0xCF reset 3 each. cmd_valid is high for exactly one cycle, in the cycle after the final frame byte is accepted.
- R2: For single and DMA opcodes, cmd_addr is the first three parameter bytes, most significant first. DMA opcodes add a 16-bit size in parameter bytes 3 and 4, and extended DMA opcodes a 24-bit size in bytes 3 to 5. Any field that an opcode does not carry reads as zero.
- R3: For the internal opcodes, cmd_clockless is bit 7 of parameter byte 0. cmd_addr is the 15-bit value made of bits 6..0 of byte 0 followed by byte 1. The third byte of an internal read is ignored.
- R4: cmd_wdata is 32 bits, most significant byte first. It comes from parameter bytes 3 to 6 of a single write and bytes 2 to 5 of an internal write.
- R5: With checking on, one extra byte follows the parameters. Bits 7..1 of that byte must equal a CRC7 with polynomial 0x09, seeded with 0x7F, run MSB first over the opcode and every parameter byte. Bit 0 is ignored. A mismatch gives status 0x02 and no strobe.
- R6: crc_en is sampled with the opcode byte and holds for the whole frame. With it low, the frame has no CRC byte.
- R7: An opcode that is not in the R1 list ends the frame at once. It produces no strobe and answers with the echoed byte followed by status 0x01.
- R8: The answer is the echoed opcode and then the status byte, which is 0x00 on success. For 0xC5, 0xC6 and 0xCF a byte of 0x00 comes first. rsp_byte moves to the next byte only on a cycle where rsp_valid and rsp_ready are both high, and holds otherwise.
- R9: Raising cs_n returns the parser to waiting for an opcode. It drops any partial frame without a strobe and clears rsp_valid within one cycle.
- R10: After a frame has completed, bytes are ignored until cs_n rises, so each select produces at most one strobe and one answer.
- R11: Out of reset, cmd_valid and rsp_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| crc_en | input | 1 | Frame CRC checking enable, sampled with the opcode |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| rsp_ready | input | 1 | Shifter takes rsp_byte this cycle |
| cmd_valid | output | 1 | Decoded command strobe |
| cmd_op | output | 8 | Opcode of the decoded command |
| cmd_addr | output | 24 | Decoded address |
| cmd_size | output | 24 | Decoded transfer size |
| cmd_wdata | output | 32 | Decoded write data |
| cmd_clockless | output | 1 | Internal-access flag |
| rsp_valid | output | 1 | An answer byte is on offer |
| rsp_byte | output | 8 | Answer byte |

## Verification
The assertions check on every cycle that the strobe lasts a single cycle, that an answer starts together with the strobe and opens with the echoed opcode for ordinary commands, that raising select silences both outputs, and that a stalled answer byte holds steady. Only the bench scenarios can show field extraction and CRC acceptance, because those depend on the byte values. The bench therefore runs every one of the 256 opcode values with checking on and off, corrupts the check bit of every known opcode, and toggles crc_en in the middle of each frame to show that the value sampled with the opcode is the one that counts.

// File: rtl/spicd_pkg.sv
package spicd_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 24;
  localparam int SIZE_W  = 24;
  localparam int DATA_W  = 32;
  localparam int PAY_MAX = 7;
  localparam int PAY_W   = PAY_MAX * BYTE_W;
  localparam int CNT_W   = $clog2(PAY_MAX + 1);

  localparam logic [7:0] OP_DMA_WR  = 8'hC1;
  localparam logic [7:0] OP_DMA_RD  = 8'hC2;
  localparam logic [7:0] OP_INT_WR  = 8'hC3;
  localparam logic [7:0] OP_INT_RD  = 8'hC4;
  localparam logic [7:0] OP_TERM    = 8'hC5;
  localparam logic [7:0] OP_REPEAT  = 8'hC6;
  localparam logic [7:0] OP_XDMA_WR = 8'hC7;
  localparam logic [7:0] OP_XDMA_RD = 8'hC8;
  localparam logic [7:0] OP_ONE_WR  = 8'hC9;
  localparam logic [7:0] OP_ONE_RD  = 8'hCA;
  localparam logic [7:0] OP_RESET   = 8'hCF;

  localparam logic [7:0] ST_OK     = 8'h00;
  localparam logic [7:0] ST_BAD_OP = 8'h01;
  localparam logic [7:0] ST_BAD_CK = 8'h02;

  typedef enum logic [1:0] {PS_IDLE, PS_BODY, PS_HOLD} pstate_t;

  // parameter byte count per opcode, zero for an unknown opcode
  function automatic logic [CNT_W-1:0] param_bytes(input logic [7:0] op);
    case (op)
      OP_ONE_RD, OP_INT_RD, OP_TERM, OP_REPEAT, OP_RESET: param_bytes = CNT_W'(3);
      OP_DMA_WR, OP_DMA_RD:                               param_bytes = CNT_W'(5);
      OP_XDMA_WR, OP_XDMA_RD, OP_INT_WR:                  param_bytes = CNT_W'(6);
      OP_ONE_WR:                                          param_bytes = CNT_W'(7);
      default:                                            param_bytes = '0;
    endcase
  endfunction

  function automatic logic is_ctrl(input logic [7:0] op);
    is_ctrl = (op == OP_TERM) || (op == OP_REPEAT) || (op == OP_RESET);
  endfunction
endpackage

// File: rtl/spicd_crc7_step.sv
module spicd_crc7_step #(
  parameter logic [6:0] POLY = 7'h09
) (
  input  logic [6:0] crc_i,
  input  logic [7:0] data_i,
  output logic [6:0] crc_o
);
  logic [6:0] chain [0:8];

  assign chain[0] = crc_i;

  generate
    for (genvar b = 0; b < 8; b++) begin : g_bit
      logic fb;
      assign fb = chain[b][6] ^ data_i[7-b];
      assign chain[b+1] = {chain[b][5:0], 1'b0} ^ (fb ? POLY : 7'h00);
    end
  endgenerate

  assign crc_o = chain[8];
endmodule

// File: rtl/spicd_field_dec.sv
module spicd_field_dec
  import spicd_pkg::*;
(
  input  logic [7:0]        op_i,
  input  logic [PAY_W-1:0]  pay_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              clockless_o
);
  // the payload register holds the last byte received in bits 7..0
  always_comb begin
    addr_o      = '0;
    size_o      = '0;
    wdata_o     = '0;
    clockless_o = 1'b0;
    case (op_i)
      OP_ONE_RD: addr_o = pay_i[23:0];
      OP_ONE_WR: begin
        addr_o  = pay_i[55:32];
        wdata_o = pay_i[31:0];
      end
      OP_DMA_WR, OP_DMA_RD: begin
        addr_o = pay_i[39:16];
        size_o = {8'h00, pay_i[15:0]};
      end
      OP_XDMA_WR, OP_XDMA_RD: begin
        addr_o = pay_i[47:24];
        size_o = pay_i[23:0];
      end
      OP_INT_RD: begin
        clockless_o = pay_i[23];
        addr_o      = {9'h000, pay_i[22:8]};
      end
      OP_INT_WR: begin
        clockless_o = pay_i[47];
        addr_o      = {9'h000, pay_i[46:32]};
        wdata_o     = pay_i[31:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/spicd_rsp_seq.sv
module spicd_rsp_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       start_i,
  input  logic       skip_i,
  input  logic [7:0] echo_i,
  input  logic [7:0] stat_i,
  input  logic       rsp_ready,
  output logic       rsp_valid,
  output logic [7:0] rsp_byte
);
  logic [2:0] pend_q, pend_d;
  logic [7:0] echo_q, stat_q;

  always_comb begin
    pend_d = pend_q;
    if (cs_n) begin
      pend_d = '0;
    end else if (start_i) begin
      pend_d = {skip_i, 2'b11};
    end else if (rsp_ready && (pend_q != 3'b000)) begin
      if (pend_q[2])      pend_d[2] = 1'b0;
      else if (pend_q[1]) pend_d[1] = 1'b0;
      else                pend_d[0] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      echo_q <= '0;
      stat_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (start_i && !cs_n) begin
        echo_q <= echo_i;
        stat_q <= stat_i;
      end
    end
  end

  assign rsp_valid = |pend_q;
  assign rsp_byte  = pend_q[2] ? 8'h00 : (pend_q[1] ? echo_q : stat_q);

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && !cs_n) |=> (rsp_valid && $stable(rsp_byte))); // R8
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spicd_pkg::*;
#(
  parameter logic [6:0] CRC_SEED = 7'h7F,
  parameter logic [6:0] CRC_POLY = 7'h09
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              crc_en,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rsp_ready,
  output logic              cmd_valid,
  output logic [7:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [SIZE_W-1:0] cmd_size,
  output logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_clockless,
  output logic              rsp_valid,
  output logic [7:0]        rsp_byte
);
  pstate_t          state_q, state_d;
  logic [7:0]       op_q, op_d;
  logic             ck_on_q, ck_on_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, need_q, need_d, need_now;
  logic [6:0]       crc_q, crc_d, crc_in, crc_step;
  logic [PAY_W-1:0] pay_q, pay_d;
  logic             in_pay, finish;
  logic [7:0]       fin_stat;
  logic             load_cmd;

  logic [ADDR_W-1:0] dec_addr;
  logic [SIZE_W-1:0] dec_size;
  logic [DATA_W-1:0] dec_wdata;
  logic              dec_clockless;

  logic              cmd_valid_q;
  logic [7:0]        cmd_op_q;
  logic [ADDR_W-1:0] cmd_addr_q;
  logic [SIZE_W-1:0] cmd_size_q;
  logic [DATA_W-1:0] cmd_wdata_q;
  logic              cmd_clockless_q;

  assign need_now = param_bytes(rx_byte);
  assign crc_in   = (state_q == PS_IDLE) ? CRC_SEED : crc_q;
  assign in_pay   = (state_q == PS_BODY) && (cnt_q < need_q);

  spicd_crc7_step #(.POLY(CRC_POLY)) crc_i (
    .crc_i  (crc_in),
    .data_i (rx_byte),
    .crc_o  (crc_step)
  );

  // payload shift register, next value
  always_comb begin
    pay_d = pay_q;
    if (!cs_n && rx_valid) begin
      if (state_q == PS_IDLE)
        pay_d = '0;
      else if (in_pay)
        pay_d = {pay_q[PAY_W-BYTE_W-1:0], rx_byte};
    end
  end

  spicd_field_dec dec_i (
    .op_i        (op_q),
    .pay_i       (pay_d),
    .addr_o      (dec_addr),
    .size_o      (dec_size),
    .wdata_o     (dec_wdata),
    .clockless_o (dec_clockless)
  );

  // frame parser, next state
  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    ck_on_d  = ck_on_q;
    cnt_d    = cnt_q;
    need_d   = need_q;
    crc_d    = crc_q;
    finish   = 1'b0;
    fin_stat = ST_OK;
    if (cs_n) begin
      state_d = PS_IDLE;
      cnt_d   = '0;
    end else if (rx_valid) begin
      case (state_q)
        PS_IDLE: begin
          op_d    = rx_byte;
          ck_on_d = crc_en;
          cnt_d   = '0;
          need_d  = need_now;
          crc_d   = crc_step;
          if (need_now == '0) begin
            finish   = 1'b1;
            fin_stat = ST_BAD_OP;
            state_d  = PS_HOLD;
          end else begin
            state_d = PS_BODY;
          end
        end
        PS_BODY: begin
          if (cnt_q < need_q) begin
            crc_d = crc_step;
            cnt_d = cnt_q + CNT_W'(1);
            if ((cnt_q == need_q - CNT_W'(1)) && !ck_on_q) begin
              finish  = 1'b1;
              state_d = PS_HOLD;
            end
          end else begin
            finish   = 1'b1;
            fin_stat = (rx_byte[7:1] == crc_q) ? ST_OK : ST_BAD_CK;
            state_d  = PS_HOLD;
          end
        end
        default: ;
      endcase
    end
  end

  assign load_cmd = finish && (fin_stat == ST_OK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      op_q    <= '0;
      ck_on_q <= 1'b0;
      cnt_q   <= '0;
      need_q  <= '0;
      crc_q   <= '0;
      pay_q   <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      ck_on_q <= ck_on_d;
      cnt_q   <= cnt_d;
      need_q  <= need_d;
      crc_q   <= crc_d;
      pay_q   <= pay_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid_q     <= 1'b0;
      cmd_op_q        <= '0;
      cmd_addr_q      <= '0;
      cmd_size_q      <= '0;
      cmd_wdata_q     <= '0;
      cmd_clockless_q <= 1'b0;
    end else begin
      cmd_valid_q <= load_cmd;
      if (load_cmd) begin
        cmd_op_q        <= op_q;
        cmd_addr_q      <= dec_addr;
        cmd_size_q      <= dec_size;
        cmd_wdata_q     <= dec_wdata;
        cmd_clockless_q <= dec_clockless;
      end
    end
  end

  assign cmd_valid     = cmd_valid_q;
  assign cmd_op        = cmd_op_q;
  assign cmd_addr      = cmd_addr_q;
  assign cmd_size      = cmd_size_q;
  assign cmd_wdata     = cmd_wdata_q;
  assign cmd_clockless = cmd_clockless_q;

  spicd_rsp_seq rsp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .start_i   (finish),
    .skip_i    (is_ctrl(op_d)),
    .echo_i    (op_d),
    .stat_i    (fin_stat),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_byte  (rsp_byte)
  );

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R10
  AST_CS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!cmd_valid && !rsp_valid)); // R9
  AST_STROBE_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> rsp_valid); // R8
  AST_STROBE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !is_ctrl(cmd_op)) |-> (rsp_byte == cmd_op)); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_BODY) |-> (cnt_q <= need_q)); // R1
  AST_KNOWN_OP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (param_bytes(cmd_op) != '0)); // R7
endmodule

// File: tb/spi_cmd_decoder_tb.sv
`timescale 1ns/1ps
module spi_cmd_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, cs_n, crc_en, rx_valid, rsp_ready;
  logic [7:0]  rx_byte;
  logic        cmd_valid, cmd_clockless, rsp_valid;
  logic [7:0]  cmd_op, rsp_byte;
  logic [23:0] cmd_addr, cmd_size;
  logic [31:0] cmd_wdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spi_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .crc_en(crc_en),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rsp_ready(rsp_ready),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_size(cmd_size), .cmd_wdata(cmd_wdata), .cmd_clockless(cmd_clockless),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte)
  );

  // capture of strobes and accepted answer bytes, sampled after the falling edge
  int          scnt, rcnt;
  logic [7:0]  rc [0:7];
  logic [7:0]  c_op;
  logic [23:0] c_addr, c_size;
  logic [31:0] c_wdata;
  logic        c_cl;

  always @(negedge clk) begin
    #1;
    if (cmd_valid) begin
      scnt++;
      c_op = cmd_op; c_addr = cmd_addr; c_size = cmd_size;
      c_wdata = cmd_wdata; c_cl = cmd_clockless;
    end
    if (rsp_valid && rsp_ready) begin
      if (rcnt < 8) rc[rcnt] = rsp_byte;
      rcnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int npar(input logic [7:0] op);
    case (op)
      8'hCA, 8'hC4, 8'hC5, 8'hC6, 8'hCF: npar = 3;
      8'hC1, 8'hC2:                      npar = 5;
      8'hC7, 8'hC8, 8'hC3:               npar = 6;
      8'hC9:                             npar = 7;
      default:                           npar = 0;
    endcase
  endfunction

  function automatic logic [6:0] crc_upd(input logic [6:0] c, input logic [7:0] d);
    logic [6:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic f = r[6] ^ d[i];
      r = {r[5:0], 1'b0} ^ (f ? 7'h09 : 7'h00);
    end
    return r;
  endfunction

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic close_sel();
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    scnt = 0; rcnt = 0;
  endtask

  logic [7:0] p [0:6];

  // corrupt: 0 none, 1 flip check bit 1, 2 flip bit 0 (ignored)
  task automatic run_frame(input logic [7:0] op, input bit ck, input int corrupt);
    int np = npar(op);
    bit known = (np != 0);
    bit ctrl = (op == 8'hC5) || (op == 8'hC6) || (op == 8'hCF);
    bit good = known && !(ck && corrupt == 1);
    logic [6:0] c = 7'h7F;
    logic [7:0] st, cb;
    logic [23:0] ea, es;
    logic [31:0] ew;
    logic ecl;
    @(negedge clk);
    cs_n = 1'b0; crc_en = ck;
    send(op);
    crc_en = !ck;  // R6: only the value at the opcode counts
    c = crc_upd(c, op);
    for (int k = 0; k < np; k++) begin
      if (ctrl) p[k] = (op == 8'hCF) ? 8'hFF : 8'h00;
      else      p[k] = 8'(op * 29 + k * 53 + (ck ? 101 : 0) + 8'h3A);
      send(p[k]);
      c = crc_upd(c, p[k]);
    end
    if (ck && known) begin
      cb = {c, 1'b0};
      if (corrupt == 1) cb ^= 8'h02;
      if (corrupt == 2) cb ^= 8'h01;
      send(cb);
    end
    repeat (6) @(negedge clk);
    st = !known ? 8'h01 : (good ? 8'h00 : 8'h02);
    chk(scnt == (good ? 1 : 0), known ? (ck ? "R5" : "R1") : "R7", scnt, good ? 1 : 0);
    if (good) begin
      ea = '0; es = '0; ew = '0; ecl = 1'b0;
      case (op)
        8'hCA: ea = {p[0], p[1], p[2]};
        8'hC9: begin ea = {p[0], p[1], p[2]}; ew = {p[3], p[4], p[5], p[6]}; end
        8'hC1, 8'hC2: begin ea = {p[0], p[1], p[2]}; es = {8'h00, p[3], p[4]}; end
        8'hC7, 8'hC8: begin ea = {p[0], p[1], p[2]}; es = {p[3], p[4], p[5]}; end
        8'hC4: begin ecl = p[0][7]; ea = {9'h000, p[0][6:0], p[1]}; end
        8'hC3: begin ecl = p[0][7]; ea = {9'h000, p[0][6:0], p[1]}; ew = {p[2], p[3], p[4], p[5]}; end
        default: ;
      endcase
      chk(c_op == op, "R1", c_op, op);
      chk(c_addr == ea, (op == 8'hC3 || op == 8'hC4) ? "R3" : "R2", c_addr, ea);
      chk(c_size == es, "R2", c_size, es);
      chk(c_wdata == ew, "R4", c_wdata, ew);
      chk(c_cl == ecl, "R3", c_cl, ecl);
    end
    chk(rcnt == (ctrl ? 3 : 2), "R8", rcnt, ctrl ? 3 : 2);
    if (ctrl) begin
      chk(rc[0] == 8'h00, "R8", rc[0], 8'h00);
      chk(rc[1] == op, "R8", rc[1], op);
      chk(rc[2] == st, ck ? "R5" : "R8", rc[2], st);
    end else begin
      chk(rc[0] == op, known ? "R8" : "R7", rc[0], op);
      chk(rc[1] == st, known ? "R5" : "R7", rc[1], st);
    end
    close_sel();
  endtask

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; crc_en = 1'b0; rx_valid = 1'b0;
    rx_byte = '0; rsp_ready = 1'b1; scnt = 0; rcnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R11", cmd_valid, 0);
    chk(rsp_valid == 1'b0, "R11", rsp_valid, 0);

    // all opcode values, checking off and on
    for (int ck = 0; ck < 2; ck++)
      for (int op = 0; op < 256; op++)
        run_frame(8'(op), ck[0], 0);

    // corrupted and ignored check bits
    for (int op = 8'hC1; op <= 8'hCF; op++)
      if (npar(8'(op)) != 0) begin
        run_frame(8'(op), 1'b1, 1);
        run_frame(8'(op), 1'b1, 2);
      end

    // R9: partial frame dropped, next frame fine
    @(negedge clk); cs_n = 1'b0; crc_en = 1'b0;
    send(8'hC9); send(8'h11); send(8'h22); send(8'h33);
    @(negedge clk); cs_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(scnt == 0, "R9", scnt, 0);
    chk(rcnt == 0, "R9", rcnt, 0);
    close_sel();
    run_frame(8'hCA, 1'b0, 0);

    // R9: pending answer dropped when select rises
    rsp_ready = 1'b0;
    @(negedge clk); cs_n = 1'b0; crc_en = 1'b0;
    send(8'hCA); send(8'h01); send(8'h02); send(8'h03);
    repeat (2) @(negedge clk);
    chk(rsp_valid == 1'b1, "R8", rsp_valid, 1);
    cs_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9", rsp_valid, 0);
    close_sel();

    // R8: stalled answer holds its first byte
    @(negedge clk); cs_n = 1'b0;
    send(8'hC5); send(8'h00); send(8'h00); send(8'h00);
    repeat (4) @(negedge clk);
    chk(rsp_valid && rsp_byte == 8'h00, "R8", rsp_byte, 8'h00);
    chk(rcnt == 0, "R8", rcnt, 0);
    rsp_ready = 1'b1;
    repeat (5) @(negedge clk);
    chk(rcnt == 3 && rc[1] == 8'hC5 && rc[2] == 8'h00, "R8", {rc[1], rc[2]}, 16'hC500);
    close_sel();

    // R10: bytes after a finished frame are ignored
    @(negedge clk); cs_n = 1'b0;
    send(8'hCA); send(8'h0A); send(8'h0B); send(8'h0C);
    send(8'hC9); send(8'hCA); send(8'h77); send(8'h66); send(8'h55);
    repeat (6) @(negedge clk);
    chk(scnt == 1, "R10", scnt, 1);
    chk(c_addr == 24'h0A0B0C, "R10", c_addr, 24'h0A0B0C);
    chk(rcnt == 2 && rc[0] == 8'hCA, "R10", rcnt, 2);
    close_sel();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule